// File: doc/BRIEF.md
# Stereo DC-Offset Removal Filter

This block removes a slowly varying DC offset from a pair of audio streams (left and right) that arrive at the final, fully decimated sample rate. Each channel runs a first-order recursive high-pass filter. Its pole lies at 1 - 2^-12, so the feedback coefficient needs only a shift and a subtract. At a 44.1 kHz sample rate the -3 dB corner falls close to 1.7 Hz, and the response has no ripple in the passband. The block sits after the decimation chain and has no effect on it.

A sample arrives as one strobe carrying two 18-bit signed words. The filtered pair appears one clock later with its own strobe, and the outputs hold their value between strobes. An enable input, sampled on each strobe, chooses between filtering and a bit-exact pass-through. While the filter is bypassed, the input history keeps tracking the incoming samples and the feedback state is cleared. When the filter is enabled again, it therefore starts cleanly instead of producing a large step. The feedback state carries 12 fractional bits beyond the sample width plus one integer guard bit. The output is rounded and saturated to the 18-bit range instead of wrapping.

Top module: `dcr_hpf`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, both outputs are 0, and both channels' stored previous input and feedback state are 0.
- R2: `out_valid` is 1 in exactly the cycle after each cycle in which `in_valid` is 1, including back-to-back strobes, and is 0 otherwise.
- R3: With `hpf_en`=1 on a strobe, each channel computes a = clamp(((x - xp) * 4096) + a_prev - floor(a_prev / 4096)). Here xp is the previous input and a_prev is the previous state. The clamp limits the state to the range [-2^30, 2^30 - 1], and the output is floor((a + 2048) / 4096).
- R4: The filtered output saturates to the range [-131072, 131071] and never wraps, for example on a full-scale swing from negative to positive.
- R5: With `hpf_en`=0 on a strobe, each output equals that strobe's input exactly.
- R6: A bypassed strobe stores its input as the previous input and clears the feedback state. The first filtered output after bypass is therefore x minus the last bypassed input.
- R7: The left and right channels keep separate state; activity on one channel never changes the other channel's output.
- R8: Between strobes, both outputs hold their last value, and a change on `hpf_en` without a strobe has no effect.
- R9: A constant input of 10000 held for 40000 filtered samples decays at the output to a magnitude of 2 or less.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hpf_en | input | 1 | 1 = filter, 0 = pass-through; sampled with `in_valid` |
| in_valid | input | 1 | Strobe marking a new sample pair |
| in_l | input | 18 | Left input sample, signed two's complement |
| in_r | input | 18 | Right input sample, signed two's complement |
| out_valid | output | 1 | Strobe marking a new output pair, one cycle after `in_valid` |
| out_l | output | 18 | Left output sample, signed |
| out_r | output | 18 | Right output sample, signed |

## Verification
The bound checker checks the timing contract on every cycle: the one-cycle strobe latency with no spurious strobes, the exact pass-through when bypassed, and the holding of outputs between strobes. The numerical behaviour can only be shown by the bench's scenarios, because it depends on the history of samples. Those scenarios cover the recursion with its rounding and state clamp, saturation on a full-scale swing, the clean restart after bypass, channel independence, and the long-run decay of a DC level. The scoreboard compares each output pair against a model written from the requirement equations.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    localparam int DCR_SAMPLE_W   = 18;
    localparam int DCR_GUARD_FRAC = 12;
    localparam int DCR_POLE_SHIFT = 12;
    localparam int DCR_CHANNELS   = 2;

    typedef enum logic {
        MODE_BYPASS = 1'b0,
        MODE_FILTER = 1'b1
    } dcr_mode_e;

    function automatic dcr_mode_e mode_from_pin(input logic en);
        return en ? MODE_FILTER : MODE_BYPASS;
    endfunction

endpackage

// File: rtl/dcr_chan.sv
module dcr_chan
    import dcr_pkg::*;
#(
    parameter int W     = DCR_SAMPLE_W,
    parameter int FRAC  = DCR_GUARD_FRAC,
    parameter int SHIFT = DCR_POLE_SHIFT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step,
    input  dcr_mode_e           mode,
    input  logic signed [W-1:0] x,
    output logic signed [W-1:0] y
);

    localparam int AS    = W + FRAC + 1;
    localparam int ACC_W = W + FRAC + 3;

    localparam logic signed [ACC_W-1:0] ACC_HI = {{(ACC_W-AS+1){1'b0}}, {(AS-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_LO = {{(ACC_W-AS+1){1'b1}}, {(AS-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] Y_HI   = {{(ACC_W-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] Y_LO   = {{(ACC_W-W+1){1'b1}}, {(W-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] HALF   = {{(ACC_W-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};

    typedef struct packed {
        logic [W-1:0]  xprev;
        logic [AS-1:0] acc;
    } chan_state_t;

    chan_state_t st_q, st_d;
    logic signed [W-1:0]     y_d;
    logic signed [W-1:0]     filt;
    logic signed [ACC_W-1:0] x_e, xp_e, acc_e, diff, sum, rnd, rsh;
    logic signed [AS-1:0]    acc_new;

    always_comb begin
        x_e   = {{(ACC_W-W){x[W-1]}}, x};
        xp_e  = {{(ACC_W-W){st_q.xprev[W-1]}}, st_q.xprev};
        acc_e = {{(ACC_W-AS){st_q.acc[AS-1]}}, st_q.acc};
        diff  = x_e - xp_e;
        sum   = (diff <<< FRAC) + acc_e - (acc_e >>> SHIFT);

        if (sum > ACC_HI)      acc_new = {1'b0, {(AS-1){1'b1}}};
        else if (sum < ACC_LO) acc_new = {1'b1, {(AS-1){1'b0}}};
        else                   acc_new = sum[AS-1:0];

        rnd = {{(ACC_W-AS){acc_new[AS-1]}}, acc_new} + HALF;
        rsh = rnd >>> FRAC;

        if (rsh > Y_HI)      filt = {1'b0, {(W-1){1'b1}}};
        else if (rsh < Y_LO) filt = {1'b1, {(W-1){1'b0}}};
        else                 filt = rsh[W-1:0];
    end

    always_comb begin
        st_d = st_q;
        y_d  = y;
        if (step) begin
            st_d.xprev = x;
            if (mode == MODE_FILTER) begin
                st_d.acc = acc_new;
                y_d      = filt;
            end else begin
                st_d.acc = '0;
                y_d      = x;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            y    <= '0;
        end else begin
            st_q <= st_d;
            y    <= y_d;
        end
    end

endmodule

// File: rtl/dcr_hpf.sv
module dcr_hpf
    import dcr_pkg::*;
#(
    parameter int W     = DCR_SAMPLE_W,
    parameter int FRAC  = DCR_GUARD_FRAC,
    parameter int SHIFT = DCR_POLE_SHIFT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hpf_en,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_l,
    input  logic signed [W-1:0] in_r,
    output logic                out_valid,
    output logic signed [W-1:0] out_l,
    output logic signed [W-1:0] out_r
);

    localparam int NCH = DCR_CHANNELS;

    dcr_mode_e           mode;
    logic signed [W-1:0] ch_in  [NCH];
    logic signed [W-1:0] ch_out [NCH];

    assign mode     = mode_from_pin(hpf_en);
    assign ch_in[0] = in_l;
    assign ch_in[1] = in_r;
    assign out_l    = ch_out[0];
    assign out_r    = ch_out[1];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dcr_chan #(
            .W     (W),
            .FRAC  (FRAC),
            .SHIFT (SHIFT)
        ) u_chan (
            .clk  (clk),
            .rst  (rst),
            .step (in_valid),
            .mode (mode),
            .x    (ch_in[c]),
            .y    (ch_out[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
    end

endmodule

// File: rtl/dcr_hpf_chk.sv
module dcr_hpf_chk #(
    parameter int W = 18
) (
    input logic                clk,
    input logic                rst,
    input logic                hpf_en,
    input logic                in_valid,
    input logic signed [W-1:0] in_l,
    input logic signed [W-1:0] in_r,
    input logic                out_valid,
    input logic signed [W-1:0] out_l,
    input logic signed [W-1:0] out_r
);

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_bypass_exact_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !hpf_en) |=> (out_l == $past(in_l)) && (out_r == $past(in_r)));

    p_hold_between_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_l) && $stable(out_r));

endmodule

bind dcr_hpf dcr_hpf_chk #(.W(W)) u_dcr_chk (
    .clk       (clk),
    .rst       (rst),
    .hpf_en    (hpf_en),
    .in_valid  (in_valid),
    .in_l      (in_l),
    .in_r      (in_r),
    .out_valid (out_valid),
    .out_l     (out_l),
    .out_r     (out_r)
);

// File: tb/tb_dcr_hpf.sv
`timescale 1ns/1ps
module tb_dcr_hpf;

    localparam int W = 18;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                hpf_en = 1'b0;
    logic                in_valid = 1'b0;
    logic signed [W-1:0] in_l = '0;
    logic signed [W-1:0] in_r = '0;
    logic                out_valid;
    logic signed [W-1:0] out_l, out_r;

    int checks = 0;
    int errors = 0;

    typedef struct {
        longint l;
        longint r;
        string  tag;
    } exp_t;

    exp_t   sb[$];
    longint m_xp [2];
    longint m_a  [2];
    bit     started = 0;
    logic signed [W-1:0] last_l = '0, last_r = '0;

    always #2.5 clk = ~clk;

    dcr_hpf dut (
        .clk(clk), .rst(rst), .hpf_en(hpf_en), .in_valid(in_valid),
        .in_l(in_l), .in_r(in_r), .out_valid(out_valid), .out_l(out_l), .out_r(out_r)
    );

    // model built from the requirement equations (R3, R4, R5, R6)
    function automatic longint model_step(input int ch, input longint x, input bit en);
        longint a, y;
        if (!en) begin
            m_xp[ch] = x;
            m_a[ch]  = 0;
            return x;
        end
        a = ((x - m_xp[ch]) * 4096) + m_a[ch] - (m_a[ch] >>> 12);
        if (a > 64'sd1073741823) a = 64'sd1073741823;
        if (a < -64'sd1073741824) a = -64'sd1073741824;
        m_a[ch]  = a;
        m_xp[ch] = x;
        y = (a + 2048) >>> 12;
        if (y > 131071) y = 131071;
        if (y < -131072) y = -131072;
        return y;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: called at a falling edge, leaves at a falling edge
    task automatic send(input longint l, input longint r, input bit en, input int gap, input string tag);
        exp_t e;
        e.l = model_step(0, l, en);
        e.r = model_step(1, r, en);
        e.tag = tag;
        sb.push_back(e);
        in_l = W'(l);
        in_r = W'(r);
        hpf_en = en;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2 unexpected out_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(longint'(out_l) == e.l, {e.tag, " left"}, longint'(out_l), e.l);
                    check(longint'(out_r) == e.r, {e.tag, " right"}, longint'(out_r), e.r);
                end
                last_l  = out_l;
                last_r  = out_r;
                started = 1;
            end else if (started) begin
                if (out_l !== last_l || out_r !== last_r)
                    check(1'b0, "R8 output moved without strobe", longint'(out_l), longint'(last_l));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_xp[0] = 0; m_xp[1] = 0; m_a[0] = 0; m_a[1] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid in reset", longint'(out_valid), 0);
        check(out_l == 0 && out_r == 0, "R1 outputs in reset", longint'(out_l), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);

        // R1/R3: first filtered sample from zeroed state equals the input
        send(1000, -500, 1, 2, "R1 R3 first from reset");

        // R5: bypass
        send(12345, -54321, 0, 1, "R5 bypass");
        send(-131072, 131071, 0, 0, "R5 bypass extremes");
        send(7, -7, 0, 3, "R5 bypass small");

        // R6: re-enable after bypass, first output = x - last bypassed
        send(107, 93, 1, 1, "R6 re-enable step");

        // R3: varied filtered stream, back-to-back strobes (R2)
        for (int i = 0; i < 60; i++) begin
            longint vl = longint'($signed(18'($urandom())));
            longint vr = longint'($signed(18'($urandom())));
            send(vl, vr, 1, i % 3, "R3 R2 filtered stream");
        end

        // R7: left active, right held at 0
        send(0, 0, 0, 1, "R7 setup");
        for (int i = 0; i < 20; i++)
            send(longint'(i * 3000 - 20000), 0, 1, 0, "R7 channel independence");

        // R8: toggle enable without strobe
        hpf_en = 1'b0;
        repeat (3) @(negedge clk);
        hpf_en = 1'b1;
        repeat (2) @(negedge clk);

        // R4: full-scale swing saturates
        send(-131072, 131071, 0, 1, "R4 setup");
        send(131071, -131072, 1, 1, "R4 saturation swing");
        send(131071, -131072, 1, 1, "R4 saturation hold");
        send(-131072, 131071, 1, 1, "R4 saturation reverse");

        // R9: DC decay
        send(0, 0, 0, 1, "R9 setup");
        for (int i = 0; i < 40000; i++)
            send(10000, -10000, 1, 1, "R9 decay stream");
        repeat (3) @(negedge clk);
        check(out_l <= 2 && out_l >= -2, "R9 left decayed", longint'(out_l), 0);
        check(out_r <= 2 && out_r >= -2, "R9 right decayed", longint'(out_r), 0);

        check(sb.size() == 0, "R2 all results delivered", sb.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule